// File: doc/BRIEF.md
# Ethernet PHY Bring-Up Sequencer

This block brings an Ethernet transceiver into service after reset. It sits above a management-bus (MDIO) master and drives it through a single request/acknowledge port. A start pulse begins the run. The sequencer probes every transceiver address from the lowest to the highest by reading the identifier register, and it keeps the first address that answers with a plausible value.

If the link is not already up, the sequencer then soft-resets the transceiver by a read-modify-write of the control register. It merges ability bits that are chosen by the requested media mode into the advertisement register, using a read-modify-write that touches only the four speed/duplex bits. It then restarts auto-negotiation. A one-cycle done pulse closes the run.

The found address, a flag for an empty bus and a flag for effective automatic mode stay on the outputs until the next start. If the requested mode selects no ability bit, the sequencer advertises all four abilities and reports automatic mode.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset, mdio_req, done, phy_missing and auto_eff are low and phy_addr is 0.
- R2: After start, register 3 is read at addresses 0, 1, 2, ... in ascending order, one read per acknowledge. The first address whose returned word is neither 16'hFFFF nor 16'h0000 is selected and shown on phy_addr.
- R3: If all 32 addresses return 16'hFFFF or 16'h0000, phy_missing is set, phy_addr stays 0, auto_eff stays 0, and done pulses with no further transaction after the read of address 31.
- R4: If link_up is low in the cycle the selecting identifier read is acknowledged, register 0 is read at the found address. It is then written back with the read value OR 16'h8000.
- R5: If link_up is high in that cycle, the soft reset is skipped, and the next transaction is a read of register 4.
- R6: Register 4 is written with (read value AND NOT 16'h01E0) OR ability. The forced media codes map as follows: 0 to 16'h0020 (10 Mb/s half), 4 to 16'h0040 (10 Mb/s full), 1 to 16'h0080 (100 Mb/s half) and 5 to 16'h0100 (100 Mb/s full). In these cases auto_eff is 0.
- R7: A media code with bit 3 set requests automatic mode. The ability is then 16'h01E0 and auto_eff is 1.
- R8: Any other media code yields no forced bit. The sequencer then falls back to ability 16'h01E0 and sets auto_eff to 1.
- R9: The last transaction writes 16'h1200 to register 0. done is high for exactly one cycle, the cycle after that write is acknowledged.
- R10: mdio_req holds with mdio_we, mdio_phy, mdio_reg and mdio_wdata stable until mdio_ack. A start pulse that arrives while a run is in progress is ignored.
- R11: media_mode is sampled in the start cycle. Later changes to it do not affect the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a bring-up run (accepted when idle) |
| media_mode | input | 4 | Requested media code |
| link_up | input | 1 | Link already established; skips soft reset |
| mdio_req | output | 1 | Transaction request to the MDIO master |
| mdio_we | output | 1 | 1 = write, 0 = read |
| mdio_phy | output | 5 | Transceiver address |
| mdio_reg | output | 5 | Register number |
| mdio_wdata | output | 16 | Write data |
| mdio_ack | input | 1 | One-cycle completion from the MDIO master |
| mdio_rdata | input | 16 | Read data, valid with mdio_ack |
| phy_addr | output | 5 | Selected transceiver address |
| phy_missing | output | 1 | No address answered validly |
| auto_eff | output | 1 | Advertisement was programmed in automatic mode |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
A wrong scan counter or validity test shows up directly in the log of transactions. An address is skipped or repeated, or a transaction begins at the wrong place. This is visible at the acknowledge of the first identifier read that goes astray. A wrong captured read word or a wrong ability mapping shows up on mdio_wdata in the single cycle of the corresponding write request. That includes a soft-reset bit lost, neighbouring bits of register 4 disturbed, or the fallback not taken. An incorrect state at the end is visible in the timing of done against the final acknowledge, and in the flag values that remain at the end of the run.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_RST_RD,
    ST_RST_WR,
    ST_ADV_RD,
    ST_ADV_WR,
    ST_ANEG_WR,
    ST_FIN
  } seq_state_e;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned REGN_W = 5;

  localparam logic [REGN_W-1:0] RN_CTRL = 5'd0;
  localparam logic [REGN_W-1:0] RN_IDENT = 5'd3;
  localparam logic [REGN_W-1:0] RN_ADV = 5'd4;

  localparam logic [WORD_W-1:0] ABIL_MASK = 16'h01E0;
  localparam logic [WORD_W-1:0] CTRL_SRST = 16'h8000;
  localparam logic [WORD_W-1:0] CTRL_RESTART = 16'h1200;

  localparam logic [WORD_W-1:0] AB_10_HALF = 16'h0020;
  localparam logic [WORD_W-1:0] AB_10_FULL = 16'h0040;
  localparam logic [WORD_W-1:0] AB_100_HALF = 16'h0080;
  localparam logic [WORD_W-1:0] AB_100_FULL = 16'h0100;

  localparam logic [3:0] MC_10_HALF = 4'd0;
  localparam logic [3:0] MC_100_HALF = 4'd1;
  localparam logic [3:0] MC_10_FULL = 4'd4;
  localparam logic [3:0] MC_100_FULL = 4'd5;
  localparam int unsigned MC_AUTO_BIT = 3;

endpackage

// File: rtl/phy_id_check.sv
module phy_id_check
  import phy_seq_pkg::*;
(
  input  logic [WORD_W-1:0] id_word,
  output logic              id_ok
);

  always_comb begin
    id_ok = (id_word != {WORD_W{1'b1}}) && (id_word != {WORD_W{1'b0}});
  end

endmodule

// File: rtl/phy_adv_map.sv
module phy_adv_map
  import phy_seq_pkg::*;
(
  input  logic [3:0]        mode,
  output logic [WORD_W-1:0] ability,
  output logic              auto_sel
);

  logic [WORD_W-1:0] forced_bits;

  always_comb begin
    unique case (mode)
      MC_10_HALF:  forced_bits = AB_10_HALF;
      MC_10_FULL:  forced_bits = AB_10_FULL;
      MC_100_HALF: forced_bits = AB_100_HALF;
      MC_100_FULL: forced_bits = AB_100_FULL;
      default:     forced_bits = '0;
    endcase
  end

  always_comb begin
    if (mode[MC_AUTO_BIT] || ((forced_bits & ABIL_MASK) == '0)) begin
      ability  = ABIL_MASK;
      auto_sel = 1'b1;
    end else begin
      ability  = forced_bits;
      auto_sel = 1'b0;
    end
  end

  always_comb begin
    assert_one_forced_bit_R6: assert (auto_sel || ($countones(ability) == 1));
  end

endmodule

// File: rtl/phy_addr_scan.sv
module phy_addr_scan #(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);

  localparam logic [ADDR_W-1:0] ADDR_TOP = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;

  always_comb begin
    addr_en = clear || (step && (addr_q != ADDR_TOP));
    addr_d  = clear ? '0 : (addr_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  assign addr = addr_q;
  assign last = (addr_q == ADDR_TOP);

  assert_scan_ascends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && !last) |=> (addr == $past(addr) + 1'b1));

  assert_scan_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (addr == '0));

endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        media_mode,
  input  logic              link_up,
  output logic              mdio_req,
  output logic              mdio_we,
  output logic [ADDR_W-1:0] mdio_phy,
  output logic [REGN_W-1:0] mdio_reg,
  output logic [WORD_W-1:0] mdio_wdata,
  input  logic              mdio_ack,
  input  logic [WORD_W-1:0] mdio_rdata,
  output logic [ADDR_W-1:0] phy_addr,
  output logic              phy_missing,
  output logic              auto_eff,
  output logic              done
);

  seq_state_e        state_q, state_d;
  logic [3:0]        mode_q, mode_d;
  logic [WORD_W-1:0] rd_q, rd_d;
  logic [ADDR_W-1:0] paddr_q, paddr_d;
  logic              miss_q, miss_d;
  logic              auto_q, auto_d;

  logic              scan_clear;
  logic              scan_step;
  logic [ADDR_W-1:0] scan_addr;
  logic              scan_last;
  logic              id_ok;
  logic [WORD_W-1:0] ability;
  logic              auto_sel;
  logic [WORD_W-1:0] adv_word;

  phy_addr_scan #(.ADDR_W(ADDR_W)) u_scan (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (scan_clear),
    .step  (scan_step),
    .addr  (scan_addr),
    .last  (scan_last)
  );

  phy_id_check u_idchk (
    .id_word (mdio_rdata),
    .id_ok   (id_ok)
  );

  phy_adv_map u_map (
    .mode     (mode_q),
    .ability  (ability),
    .auto_sel (auto_sel)
  );

  assign adv_word = (rd_q & ~ABIL_MASK) | ability;

  // next-state process
  always_comb begin
    state_d    = state_q;
    mode_d     = mode_q;
    rd_d       = rd_q;
    paddr_d    = paddr_q;
    miss_d     = miss_q;
    auto_d     = auto_q;
    scan_clear = 1'b0;
    scan_step  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          mode_d     = media_mode;
          paddr_d    = '0;
          miss_d     = 1'b0;
          auto_d     = 1'b0;
          scan_clear = 1'b1;
          state_d    = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (mdio_ack) begin
          if (id_ok) begin
            paddr_d = scan_addr;
            state_d = link_up ? ST_ADV_RD : ST_RST_RD;
          end else if (scan_last) begin
            miss_d  = 1'b1;
            state_d = ST_FIN;
          end else begin
            scan_step = 1'b1;
          end
        end
      end
      ST_RST_RD: begin
        if (mdio_ack) begin
          rd_d    = mdio_rdata;
          state_d = ST_RST_WR;
        end
      end
      ST_RST_WR: begin
        if (mdio_ack) state_d = ST_ADV_RD;
      end
      ST_ADV_RD: begin
        if (mdio_ack) begin
          rd_d    = mdio_rdata;
          state_d = ST_ADV_WR;
        end
      end
      ST_ADV_WR: begin
        if (mdio_ack) begin
          auto_d  = auto_sel;
          state_d = ST_ANEG_WR;
        end
      end
      ST_ANEG_WR: begin
        if (mdio_ack) state_d = ST_FIN;
      end
      ST_FIN: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= '0;
      rd_q    <= '0;
      paddr_q <= '0;
      miss_q  <= 1'b0;
      auto_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      rd_q    <= rd_d;
      paddr_q <= paddr_d;
      miss_q  <= miss_d;
      auto_q  <= auto_d;
    end
  end

  // request port decode
  always_comb begin
    mdio_req   = 1'b0;
    mdio_we    = 1'b0;
    mdio_phy   = paddr_q;
    mdio_reg   = RN_CTRL;
    mdio_wdata = '0;
    unique case (state_q)
      ST_SCAN: begin
        mdio_req = 1'b1;
        mdio_phy = scan_addr;
        mdio_reg = RN_IDENT;
      end
      ST_RST_RD: begin
        mdio_req = 1'b1;
      end
      ST_RST_WR: begin
        mdio_req   = 1'b1;
        mdio_we    = 1'b1;
        mdio_wdata = rd_q | CTRL_SRST;
      end
      ST_ADV_RD: begin
        mdio_req = 1'b1;
        mdio_reg = RN_ADV;
      end
      ST_ADV_WR: begin
        mdio_req   = 1'b1;
        mdio_we    = 1'b1;
        mdio_reg   = RN_ADV;
        mdio_wdata = adv_word;
      end
      ST_ANEG_WR: begin
        mdio_req   = 1'b1;
        mdio_we    = 1'b1;
        mdio_wdata = CTRL_RESTART;
      end
      default: begin
        mdio_req = 1'b0;
      end
    endcase
  end

  assign phy_addr    = paddr_q;
  assign phy_missing = miss_q;
  assign auto_eff    = auto_q;
  assign done        = (state_q == ST_FIN);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req && !mdio_ack) |=> (mdio_req && $stable(mdio_we) && $stable(mdio_phy)
                                 && $stable(mdio_reg) && $stable(mdio_wdata)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !mdio_req));

  assert_srst_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req && mdio_we && (mdio_reg == RN_CTRL) && (mdio_wdata != CTRL_RESTART))
      |-> mdio_wdata[15]);

  assert_adv_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req && mdio_we && (mdio_reg == RN_ADV))
      |-> ($countones(mdio_wdata & ABIL_MASK) != 0));

  assert_missing_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phy_missing |-> !(mdio_req && mdio_we));

endmodule

// File: tb/sim_phy_bringup_seq.sv
module sim_phy_bringup_seq;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [3:0]  media_mode;
  logic        link_up;
  logic        mdio_req;
  logic        mdio_we;
  logic [4:0]  mdio_phy;
  logic [4:0]  mdio_reg;
  logic [15:0] mdio_wdata;
  logic        mdio_ack;
  logic [15:0] mdio_rdata;
  logic [4:0]  phy_addr;
  logic        phy_missing;
  logic        auto_eff;
  logic        done;

  phy_bringup_seq u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .media_mode (media_mode),
    .link_up    (link_up),
    .mdio_req   (mdio_req),
    .mdio_we    (mdio_we),
    .mdio_phy   (mdio_phy),
    .mdio_reg   (mdio_reg),
    .mdio_wdata (mdio_wdata),
    .mdio_ack   (mdio_ack),
    .mdio_rdata (mdio_rdata),
    .phy_addr   (phy_addr),
    .phy_missing(phy_missing),
    .auto_eff   (auto_eff),
    .done       (done)
  );

  int n_tests;
  int n_fail;
  int cyc;
  int done_cnt;
  int done_cyc;
  int last_ack_cyc;
  bit finished;

  // responder configuration
  int          cfg_valid;
  logic [15:0] cfg_id;
  logic [15:0] cfg_r0;
  logic [15:0] cfg_r4;

  // transaction log
  int          log_n;
  logic        log_we  [0:63];
  logic [4:0]  log_phy [0:63];
  logic [4:0]  log_reg [0:63];
  logic [15:0] log_wd  [0:63];

  // expected transactions
  int          exp_n;
  logic        exp_we  [0:63];
  logic [4:0]  exp_phy [0:63];
  logic [4:0]  exp_reg [0:63];
  logic [15:0] exp_wd  [0:63];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (done) begin
      done_cnt <= done_cnt + 1;
      done_cyc <= cyc;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] resp_word(input logic we, input logic [4:0] pa,
                                            input logic [4:0] rn);
    if (we) return 16'h0000;
    if (rn == 5'd3) begin
      if (int'(pa) == cfg_valid) return cfg_id;
      return pa[0] ? 16'hFFFF : 16'h0000;
    end
    if (rn == 5'd0) return cfg_r0;
    if (rn == 5'd4) return cfg_r4;
    return 16'h0000;
  endfunction

  function automatic logic [15:0] exp_ability(input logic [3:0] m);
    if (m[3]) return 16'h01E0;
    case (m)
      4'd0: return 16'h0020;
      4'd4: return 16'h0040;
      4'd1: return 16'h0080;
      4'd5: return 16'h0100;
      default: return 16'h01E0;
    endcase
  endfunction

  function automatic bit exp_auto(input logic [3:0] m);
    return m[3] || !(m == 4'd0 || m == 4'd1 || m == 4'd4 || m == 4'd5);
  endfunction

  // MDIO responder with random latency; also checks request stability (R10)
  initial begin
    mdio_ack   = 1'b0;
    mdio_rdata = 16'h0;
    forever begin
      @(negedge clk);
      if (rst_n && mdio_req) begin
        logic        c_we;
        logic [4:0]  c_phy;
        logic [4:0]  c_reg;
        logic [15:0] c_wd;
        int          lat;
        c_we  = mdio_we;
        c_phy = mdio_phy;
        c_reg = mdio_reg;
        c_wd  = mdio_wdata;
        lat   = int'($urandom % 4);
        for (int k = 0; k < lat; k++) begin
          @(negedge clk);
          if (!mdio_req || mdio_we != c_we || mdio_phy != c_phy ||
              mdio_reg != c_reg || mdio_wdata != c_wd)
            check(1'b0, "R10", "request changed before ack", int'(mdio_wdata), int'(c_wd));
        end
        mdio_rdata = resp_word(c_we, c_phy, c_reg);
        mdio_ack   = 1'b1;
        if (log_n < 64) begin
          log_we[log_n]  = c_we;
          log_phy[log_n] = c_phy;
          log_reg[log_n] = c_reg;
          log_wd[log_n]  = c_wd;
        end
        log_n++;
        last_ack_cyc = cyc;
        @(negedge clk);
        mdio_ack   = 1'b0;
        mdio_rdata = 16'h0;
      end
    end
  end

  task automatic push_exp(input logic we, input logic [4:0] pa, input logic [4:0] rn,
                          input logic [15:0] wd);
    exp_we[exp_n]  = we;
    exp_phy[exp_n] = pa;
    exp_reg[exp_n] = rn;
    exp_wd[exp_n]  = wd;
    exp_n++;
  endtask

  task automatic run_case(input int valid, input logic [3:0] mode, input logic link,
                          input logic [15:0] idw, input logic [15:0] r0,
                          input logic [15:0] r4, input bit poke);
    int  top;
    bit  seq_ok;
    int  bad_i;
    cfg_valid = valid;
    cfg_id    = idw;
    cfg_r0    = r0;
    cfg_r4    = r4;
    // expected sequence from the requirements
    exp_n = 0;
    top = (valid < 32) ? valid : 31;
    for (int a = 0; a <= top; a++) push_exp(1'b0, 5'(a), 5'd3, 16'h0);   // R2
    if (valid < 32) begin
      if (!link) begin                                                    // R4
        push_exp(1'b0, 5'(valid), 5'd0, 16'h0);
        push_exp(1'b1, 5'(valid), 5'd0, r0 | 16'h8000);
      end
      push_exp(1'b0, 5'(valid), 5'd4, 16'h0);                             // R5
      push_exp(1'b1, 5'(valid), 5'd4, (r4 & ~16'h01E0) | exp_ability(mode)); // R6
      push_exp(1'b1, 5'(valid), 5'd0, 16'h1200);                          // R9
    end
    log_n    = 0;
    done_cnt = 0;
    @(negedge clk);
    start      = 1'b1;
    media_mode = mode;
    link_up    = link;
    @(negedge clk);
    start      = 1'b0;
    media_mode = ~mode;                        // R11: later change ignored
    if (poke) begin
      repeat (4) @(negedge clk);
      start      = 1'b1;                       // R10: start while busy
      media_mode = 4'd3;
      @(negedge clk);
      start = 1'b0;
    end
    for (int w = 0; w < 3000 && done_cnt == 0; w++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(done_cnt == 1, "R9", "done pulse count", done_cnt, 1);
    check(done_cyc == last_ack_cyc + 1, "R9", "done cycle after last ack",
          done_cyc - last_ack_cyc, 1);
    check(log_n == exp_n, (valid < 32) ? "R2" : "R3", "transaction count", log_n, exp_n);
    seq_ok = 1'b1;
    bad_i  = 0;
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      if (seq_ok && (log_we[i] != exp_we[i] || log_phy[i] != exp_phy[i] ||
                     log_reg[i] != exp_reg[i] || log_wd[i] != exp_wd[i])) begin
        seq_ok = 1'b0;
        bad_i  = i;
      end
    end
    check(seq_ok, link ? "R5" : "R4", "transaction contents (wdata at first mismatch)",
          int'(log_wd[bad_i]), int'(exp_wd[bad_i]));
    check(phy_addr == ((valid < 32) ? 5'(valid) : 5'd0), "R2", "phy_addr",
          int'(phy_addr), (valid < 32) ? valid : 0);
    check(phy_missing == (valid >= 32), "R3", "phy_missing",
          int'(phy_missing), int'(valid >= 32));
    check(auto_eff == ((valid < 32) && exp_auto(mode)), "R8", "auto_eff",
          int'(auto_eff), int'((valid < 32) && exp_auto(mode)));
    check(!mdio_req, "R9", "idle after done", int'(mdio_req), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    n_tests    = 0;
    n_fail     = 0;
    cyc        = 0;
    finished   = 1'b0;
    start      = 1'b0;
    media_mode = 4'd0;
    link_up    = 1'b0;
    log_n      = 0;
    cfg_valid  = 32;
    cfg_id     = 16'h0;
    cfg_r0     = 16'h0;
    cfg_r4     = 16'h0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!mdio_req && !done && !phy_missing && !auto_eff && phy_addr == 5'd0,
          "R1", "reset outputs", {mdio_req, done, phy_missing, auto_eff, phy_addr}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!mdio_req, "R1", "no request without start", int'(mdio_req), 0);

    // directed corners
    run_case(0,  4'd0, 1'b0, 16'h0141, 16'h3100, 16'hFFFF, 1'b0); // R6 10 half, R4
    run_case(31, 4'd5, 1'b1, 16'h0022, 16'h0000, 16'h0000, 1'b0); // R6 100 full, R5
    run_case(32, 4'd8, 1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b0); // R3 none found
    run_case(7,  4'd8, 1'b1, 16'h7FFF, 16'h1234, 16'hA5A5, 1'b0); // R7 auto
    run_case(3,  4'd3, 1'b0, 16'h8000, 16'h0001, 16'h0E1F, 1'b0); // R8 fallback
    run_case(12, 4'd9, 1'b0, 16'hFFFE, 16'h0800, 16'h01E0, 1'b0); // R7 bit 3 set
    run_case(5,  4'd4, 1'b1, 16'h0001, 16'h0000, 16'hFE1F, 1'b1); // R6 10 full, R10 poke
    run_case(2,  4'd1, 1'b0, 16'h1000, 16'hC000, 16'h4321, 1'b1); // R6 100 half, R11

    // constrained random
    for (int t = 0; t < 14; t++) begin
      int          v;
      logic [15:0] idv;
      v   = int'($urandom % 40);
      if (v > 32) v = 32;
      idv = 16'($urandom);
      if (idv == 16'h0000 || idv == 16'hFFFF) idv = 16'h2000;
      run_case(v, 4'($urandom), 1'($urandom), idv, 16'($urandom), 16'($urandom),
               1'($urandom));
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule